// File: doc/BRIEF.md
# Pipelined Parallel Bus Arbiter

This block decides which of N masters owns a shared synchronous bus. Each master has a request line and a grant line of its own. The arbiter samples the requests every cycle and keeps exactly one grant registered. It chooses the next owner while the current owner is still running its address and data phases. Moving the grant early in this way means a change of owner costs no idle arbitration cycles.

A master owns the bus for one tenure, which runs in this order: request, grant, one address phase, one or more data phases, release. A granted master may begin its address phase only on the cycle after it sees the bus idle. The bus is idle when no frame is active and no ready handshake is pending. The arbiter counts a tenure as started when the bus is idle and the granted master is requesting. At that moment the starting master drops to the lowest priority. The grant then moves on at once to the next requester, so the next owner is pre-granted while the current transfer runs. When nobody requests, the grant parks on a default master chosen by parameter.

Top module: `pipe_bus_arbiter`

## Requirements
- R1: While reset is held, the grant is on master DEF_MASTER (default 2 of N=4). After reset, the first decision with every master requesting goes to master 0, and the search order starts at index 0.
- R2: Exactly one bit of `gntOut` is high in every cycle. The old grant falls in the same cycle the new grant rises.
- R3: If no request is high in a cycle, `gntOut` is one-hot on DEF_MASTER in the next cycle.
- R4: Arbitration keeps running while the bus is busy (`frameActive` or `readyPending` high). The grant registered in the next cycle is the first requester found after the priority pointer, so a new master can be pre-granted during the current transfer.
- R5: A tenure starts in a cycle where the bus is idle and the granted master is requesting. In that case the starting master takes the lowest priority, and the search for the next cycle's grant begins at the index just after it.
- R6: The priority pointer changes only when a tenure starts. While either `frameActive` or `readyPending` is high, the rotation does not advance, so with requests unchanged the grant stays the same.
- R7: If the granted master drops its request while another master is requesting, its grant is removed in the next cycle and given to the next requester in round-robin order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | N | One request line per master |
| frameActive | input | 1 | A transfer frame is on the bus |
| readyPending | input | 1 | A ready handshake is still outstanding |
| gntOut | output | N | One-hot grant, one line per master |

## Verification
The bench goes after the cycle in which a tenure starts. An arbiter that failed to rotate there would hand the bus straight back to the same master and starve the others. A pointer that advanced on the wrong cycle would show the grant lagging by one owner. The bench holds the bus busy through `frameActive` alone and through `readyPending` alone; a design that ignored either signal would rotate during a live transfer. It also drops the pre-granted request and removes all requests, to catch a grant that lingers on a master that has withdrawn or fails to park on the default master.

// File: rtl/bus_arb_pkg.sv
`timescale 1ns/1ps
package bus_arb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic busIdle;   // no frame and no ready pending
    logic startNow;  // granted master begins a tenure this cycle
  } arbCtl_t;
endpackage

// File: rtl/bus_arb_ctrl.sv
`timescale 1ns/1ps
module bus_arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] reqIn,
  input  logic         frameActive,
  input  logic         readyPending,
  input  logic [N-1:0] gntQ,
  output arbCtl_t      ctl
);
  always_comb begin
    ctl.busIdle  = !frameActive && !readyPending;
    ctl.startNow = ctl.busIdle && (|(gntQ & reqIn));
  end

  // R6: no tenure start while a transfer or handshake is live
  p_busy_no_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive || readyPending) |-> !ctl.startNow);
endmodule

// File: rtl/bus_arb_dp.sv
`timescale 1ns/1ps
module bus_arb_dp
  import bus_arb_pkg::*;
#(
  parameter int N          = 4,
  parameter int DEF_MASTER = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] reqIn,
  input  arbCtl_t      ctl,
  output logic [N-1:0] gntQ
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] PTR_RST = PW'(N - 1);

  logic [PW-1:0] ptrQ, ptrEff, gntIdx;
  logic [N-1:0]  gntNxt;
  logic          found;

  // Index of the current one-hot grant
  always_comb begin
    gntIdx = '0;
    for (int i = 0; i < N; i++)
      if (gntQ[i]) gntIdx = PW'(i);
  end

  assign ptrEff = ctl.startNow ? gntIdx : ptrQ;

  // Round-robin search starting just after the pointer
  always_comb begin
    gntNxt = '0;
    found  = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(ptrEff) + k) % N;
      if (!found && reqIn[j]) begin
        gntNxt[j] = 1'b1;
        found     = 1'b1;
      end
    end
    if (!found) gntNxt[DEF_MASTER] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gntQ <= N'(1) << DEF_MASTER;
      ptrQ <= PTR_RST;
    end else begin
      gntQ <= gntNxt;
      if (ctl.startNow) ptrQ <= gntIdx;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(gntQ));

  p_park_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn == '0) |=> gntQ[DEF_MASTER]);

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.startNow |=> $stable(ptrQ));

  p_rotate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.startNow && $countones(reqIn) > 1) |=> (gntQ != $past(gntQ)));

  generate
    for (genvar g = 0; g < N; g++) begin : gDrop
      p_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
        (gntQ[g] && !reqIn[g] && (reqIn != '0)) |=> !gntQ[g]);
    end
  endgenerate
endmodule

// File: rtl/pipe_bus_arbiter.sv
`timescale 1ns/1ps
module pipe_bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter int N          = 4,
  parameter int DEF_MASTER = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] reqIn,
  input  logic         frameActive,
  input  logic         readyPending,
  output logic [N-1:0] gntOut
);
  arbCtl_t      ctl;
  logic [N-1:0] gntQ;

  bus_arb_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .frameActive(frameActive),
    .readyPending(readyPending), .gntQ(gntQ), .ctl(ctl)
  );

  bus_arb_dp #(.N(N), .DEF_MASTER(DEF_MASTER)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ctl(ctl), .gntQ(gntQ)
  );

  assign gntOut = gntQ;
endmodule

// File: tb/pipe_bus_arbiter_bench.sv
`timescale 1ns/1ps
module pipe_bus_arbiter_bench;
  localparam int N   = 4;
  localparam int DEF = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic         frameActive = 1'b0;
  logic         readyPending = 1'b0;
  logic [N-1:0] gntOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0] expGnt;
  int           expPtr;
  string        pendTag;

  pipe_bus_arbiter #(.N(N), .DEF_MASTER(DEF)) u_pipe_bus_arbiter (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .frameActive(frameActive),
    .readyPending(readyPending), .gntOut(gntOut)
  );

  always #2.5 clk = ~clk;

  function automatic logic [N-1:0] pickNext(logic [N-1:0] r, int p);
    for (int k = 1; k <= N; k++) begin
      int j = (p + k) % N;
      if (r[j]) return N'(1) << j;
    end
    return N'(1) << DEF;
  endfunction

  function automatic int idxOf(logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return i;
    return 0;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gntOut=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // At a falling edge: check the current grant, apply new inputs, predict next
  task automatic cycle(logic [N-1:0] r, logic f, logic rp, string tag);
    bit start;
    int pe;
    @(negedge clk);
    check(pendTag, gntOut, expGnt);
    checks++;
    if (!$onehot(gntOut)) begin
      fails++;
      $display("FAIL R2: gntOut=%b expected one-hot", gntOut);
    end
    reqIn = r; frameActive = f; readyPending = rp;
    start = !f && !rp && (|(expGnt & r));
    pe = start ? idxOf(expGnt) : expPtr;
    if (start) expPtr = idxOf(expGnt);
    expGnt = pickNext(r, pe);
    pendTag = tag;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset parks on the default master
    repeat (2) @(negedge clk);
    check("R1", gntOut, N'(1) << DEF);
    rstN   = 1'b1;
    expGnt = N'(1) << DEF;
    expPtr = N - 1;
    pendTag = "R1";
    // R1: first choice with all requesting is master 0 (bus busy, no start)
    cycle(4'b1111, 1'b1, 1'b0, "R1");
    // R5: idle bus, all requesting: rotation every cycle
    for (int i = 0; i < 6; i++) cycle(4'b1111, 1'b0, 1'b0, "R5");
    // R6: busy via frame only, then ready only: grant holds
    for (int i = 0; i < 3; i++) cycle(4'b1111, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 3; i++) cycle(4'b1111, 1'b0, 1'b1, "R6");
    // R4: pre-grant while busy with a changed request set
    cycle(4'b1010, 1'b1, 1'b1, "R4");
    cycle(4'b1010, 1'b1, 1'b0, "R4");
    // R7: pre-granted master withdraws before idle
    cycle(~expGnt & 4'b1010, 1'b1, 1'b0, "R7");
    cycle(4'b0110, 1'b1, 1'b0, "R7");
    // R3: no requests -> park
    cycle(4'b0000, 1'b0, 1'b0, "R3");
    cycle(4'b0000, 1'b1, 1'b0, "R3");
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      logic f, rp;
      string t;
      r  = N'($urandom_range(0, (1 << N) - 1));
      f  = ($urandom_range(0, 2) == 0);
      rp = ($urandom_range(0, 4) == 0);
      if (r == '0) t = "R3";
      else if (f || rp) t = "R4";
      else if (|(expGnt & r)) t = "R5";
      else t = "R7";
      cycle(r, f, rp, t);
    end
    cycle(4'b0000, 1'b0, 1'b0, "R3");
    @(negedge clk);
    check(pendTag, gntOut, expGnt);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule